// File: doc/BRIEF.md
# Reset Pulse and Register Init Controller

This block controls the reset functions of a register file. Software can ask for a timed, low-going reset pulse on a shared open-drain pin. The request is honoured only after a separate enable bit has been armed. The same pin also serves as an external active-low reset input. A second software bit starts an initialization of the configuration register group.

The register file itself owns the register bits. It passes the relevant written bits and their write strobes to this block. It reads the self-clearing request state and the enable state back from this block. It resets its registers from two group strobes. The configuration group is restored both by the external reset and by the software initialization. The auxiliary group (test and analog-output registers) is restored only by the external reset. Value, limit and DAC registers receive no strobe at all.

The pulse length is a number of clock cycles computed from `CLK_HZ` and `PULSE_MS`. While the block drives the pin, it ignores the pin level. It keeps ignoring the pin for `SYNC_STAGES` cycles after release, so that it cannot reset itself.

Top module: `rstctl_top`

## Requirements
- R1: During and directly after reset, `pin_oe_o`, `pulse_busy_o`, `pulse_en_o`, `cfg_grp_rst_o` and `aux_grp_rst_o` are all 0.
- R2: A write with `mask_wr_i` high loads `mask_en_bit_i` into the enable bit. The enable bit is visible on `pulse_en_o` from the cycle after the write.
- R3: A configuration write with `cfg_pulse_bit_i` = 1 while the enable bit is 1 and no pulse is running raises `pin_oe_o` in the following cycle. It holds `pin_oe_o` high for exactly (CLK_HZ/1000)*PULSE_MS cycles.
- R4: A pulse request made while the enable bit is 0 produces no pulse.
- R5: `pulse_busy_o` (the request bit's readback) is 1 for exactly the cycles in which the pulse is driven. It returns to 0 by itself when the pulse ends.
- R6: A pulse request arriving while a pulse is running is ignored. The running pulse keeps its original end time.
- R7: A configuration write with `cfg_init_bit_i` = 1 does four things: it raises `cfg_grp_rst_o` for exactly one cycle, it leaves `aux_grp_rst_o` at 0, it clears the enable bit, and it stops any running pulse in the next cycle. It also takes priority over a pulse request in the same write.
- R8: A low level on `pin_i` passes through a `SYNC_STAGES`-flop synchronizer (2 by default). It raises `aux_grp_rst_o` and `cfg_grp_rst_o` `SYNC_STAGES` cycles after it is first sampled, and they stay high while the pin stays low. This clears the enable bit.
- R9: While `pin_oe_o` is high, and for `SYNC_STAGES` cycles after it falls, the pin level causes no group reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| cfg_wr_i | input | 1 | Write strobe of the configuration register |
| cfg_pulse_bit_i | input | 1 | Written pulse-request bit |
| cfg_init_bit_i | input | 1 | Written initialization bit |
| mask_wr_i | input | 1 | Write strobe of the mask register that holds the enable |
| mask_en_bit_i | input | 1 | Written pulse-enable bit |
| pin_i | input | 1 | Level sampled at the reset pin (asynchronous) |
| pin_oe_o | output | 1 | Drive the reset pin low |
| pulse_busy_o | output | 1 | Readback of the self-clearing pulse request bit |
| pulse_en_o | output | 1 | Readback of the pulse enable bit |
| cfg_grp_rst_o | output | 1 | Reset strobe for the configuration register group |
| aux_grp_rst_o | output | 1 | Reset strobe for the test and analog-output registers |

## Verification
The assertions check several rules on every cycle:
- a pulse never starts unless the enable was already set;
- the pulse counter steps down by one each cycle;
- the auxiliary strobe never appears while the pin is driven;
- the init strobe rises only after an init write;
- an external reset clears the enable.

Only the bench scenarios can show the following:
- the exact pulse length;
- that a second request leaves the end time unchanged;
- the two-cycle synchronizer latency;
- the blanking window after release;
- that an init write wins over a pulse request and cancels a running pulse.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
  localparam int SYNC_DEF = 2;

  function automatic int pulse_cycles(input int clk_hz, input int ms);
    return (clk_hz / 1000) * ms;
  endfunction
endpackage

// File: rtl/rstctl_sync.sv
module rstctl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  // idle pin level is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= 1'b1;
    else         chain_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= 1'b1;
      else         chain_q[g] <= chain_q[g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rstctl_pulse.sv
module rstctl_pulse #(
  parameter int CYCLES = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  output logic active_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (abort_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i && !active_q) begin
      active_q <= 1'b1;
      cnt_q    <= CW'(CYCLES - 1);
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  assign active_o = active_q;

  // R3
  pulse_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && cnt_q != '0 && !abort_i) |=> (active_q && cnt_q == $past(cnt_q) - 1'b1));

  // R6
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !abort_i && cnt_q != '0) |=> (cnt_q != CW'(CYCLES - 1)));
endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
  import rstctl_pkg::*;
#(
  parameter int CLK_HZ      = 200_000_000,
  parameter int PULSE_MS    = 20,
  parameter int SYNC_STAGES = SYNC_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_wr_i,
  input  logic cfg_pulse_bit_i,
  input  logic cfg_init_bit_i,
  input  logic mask_wr_i,
  input  logic mask_en_bit_i,
  input  logic pin_i,
  output logic pin_oe_o,
  output logic pulse_busy_o,
  output logic pulse_en_o,
  output logic cfg_grp_rst_o,
  output logic aux_grp_rst_o
);
  localparam int PULSE_CYCLES = pulse_cycles(CLK_HZ, PULSE_MS);
  localparam int HW           = $clog2(SYNC_STAGES + 1);

  logic          pin_sync;
  logic          active;
  logic          en_q;
  logic          init_stb_q;
  logic [HW-1:0] hold_q;
  logic          blank;
  logic          ext_act;
  logic          init_req;
  logic          pulse_req;

  rstctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_sync)
  );

  assign init_req  = cfg_wr_i & cfg_init_bit_i;
  // init wins over a pulse request in the same write
  assign pulse_req = cfg_wr_i & cfg_pulse_bit_i & en_q & ~init_req & ~ext_act;

  rstctl_pulse #(.CYCLES(PULSE_CYCLES)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (pulse_req),
    .abort_i  (init_req),
    .active_o (active)
  );

  // blank the pin while driving and until the synchronizer has flushed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            hold_q <= '0;
    else if (active)        hold_q <= HW'(SYNC_STAGES);
    else if (hold_q != '0)  hold_q <= hold_q - 1'b1;
  end

  assign blank   = active | (hold_q != '0);
  assign ext_act = ~pin_sync & ~blank;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  en_q <= 1'b0;
    else if (ext_act || init_req) en_q <= 1'b0;
    else if (mask_wr_i)           en_q <= mask_en_bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) init_stb_q <= 1'b0;
    else         init_stb_q <= init_req;
  end

  assign pin_oe_o      = active;
  assign pulse_busy_o  = active;
  assign pulse_en_o    = en_q;
  assign cfg_grp_rst_o = ext_act | init_stb_q;
  assign aux_grp_rst_o = ext_act;

  // R4
  pulse_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pin_oe_o) |-> $past(en_q));

  // R9
  no_self_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_oe_o |-> !aux_grp_rst_o);

  // R7
  init_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(init_stb_q) |-> $past(cfg_wr_i && cfg_init_bit_i));

  // R8
  ext_clr_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_grp_rst_o |=> !pulse_en_o);
endmodule

// File: tb/rstctl_top_tb.sv
module rstctl_top_tb;
  localparam int CLK_HZ = 1000;
  localparam int PMS    = 20;
  localparam int PULSE  = (CLK_HZ / 1000) * PMS;

  // [12] mask_en [11] pulse_bit [10] init_bit [9:2] exp_len [1] exp_init [0] exp_en
  localparam logic [12:0] VEC [0:5] = '{
    {1'b1, 1'b1, 1'b0, 8'd20, 1'b0, 1'b1},
    {1'b0, 1'b1, 1'b0, 8'd0,  1'b0, 1'b0},
    {1'b1, 1'b1, 1'b1, 8'd0,  1'b1, 1'b0},
    {1'b1, 1'b0, 1'b1, 8'd0,  1'b1, 1'b0},
    {1'b1, 1'b0, 1'b0, 8'd0,  1'b0, 1'b1},
    {1'b0, 1'b0, 1'b1, 8'd0,  1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_p = 1'b0, cfg_i = 1'b0;
  logic mask_wr = 1'b0, mask_b = 1'b0;
  logic ext_n = 1'b1;
  logic pin, pin_oe, busy, en, cfg_rst, aux_rst;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  // open-drain pad model
  assign pin = ~pin_oe & ext_n;

  rstctl_top #(.CLK_HZ(CLK_HZ), .PULSE_MS(PMS), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_wr_i(cfg_wr), .cfg_pulse_bit_i(cfg_p), .cfg_init_bit_i(cfg_i),
    .mask_wr_i(mask_wr), .mask_en_bit_i(mask_b),
    .pin_i(pin), .pin_oe_o(pin_oe), .pulse_busy_o(busy), .pulse_en_o(en),
    .cfg_grp_rst_o(cfg_rst), .aux_grp_rst_o(aux_rst)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_mask(input logic b);
    @(negedge clk); mask_wr = 1'b1; mask_b = b;
    @(negedge clk); mask_wr = 1'b0;
  endtask

  task automatic wr_cfg(input logic p, input logic i);
    @(negedge clk); cfg_wr = 1'b1; cfg_p = p; cfg_i = i;
    @(negedge clk); cfg_wr = 1'b0; cfg_p = 1'b0; cfg_i = 1'b0;
  endtask

  // counts driven cycles from the current negedge; watches busy and aux
  task automatic count_pulse(output int n, output bit saw_aux, output bit busy_mis);
    n = 0; saw_aux = 0; busy_mis = 0;
    while (pin_oe && n < 200) begin
      n++;
      if (aux_rst) saw_aux = 1;
      if (busy !== pin_oe) busy_mis = 1;
      @(negedge clk);
    end
    if (busy !== 1'b0) busy_mis = 1;
    for (int k = 0; k < 3; k++) begin
      if (aux_rst) saw_aux = 1;
      @(negedge clk);
    end
  endtask

  initial begin
    #500_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int  n, n_rem;
    bit  sa, bm;

    // R1 reset state
    @(negedge clk);
    chk({pin_oe, busy, en, cfg_rst, aux_rst} == 5'b0, "R1 in reset",
        {pin_oe, busy, en, cfg_rst, aux_rst}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({pin_oe, busy, en, cfg_rst, aux_rst} == 5'b0, "R1 after reset",
        {pin_oe, busy, en, cfg_rst, aux_rst}, 0);

    // vector table
    for (int v = 0; v < 6; v++) begin
      do_reset();
      wr_mask(VEC[v][12]);
      chk(en == VEC[v][12], $sformatf("R2 vec%0d enable", v), en, VEC[v][12]);
      wr_cfg(VEC[v][11], VEC[v][10]);
      chk(cfg_rst == VEC[v][1], $sformatf("R7 vec%0d init strobe", v), cfg_rst, VEC[v][1]);
      chk(aux_rst == 1'b0, $sformatf("R7 vec%0d aux quiet", v), aux_rst, 0);
      count_pulse(n, sa, bm);
      chk(n == int'(VEC[v][9:2]), $sformatf("R3 R4 vec%0d pulse length", v), n, VEC[v][9:2]);
      chk(!bm, $sformatf("R5 vec%0d busy tracks pulse", v), bm, 0);
      chk(!sa, $sformatf("R9 vec%0d no self reset", v), sa, 0);
      chk(cfg_rst == 1'b0, $sformatf("R7 vec%0d strobe one cycle", v), cfg_rst, 0);
      chk(en == VEC[v][0], $sformatf("R7 vec%0d enable after", v), en, VEC[v][0]);
    end

    // R6 repeated request during pulse
    do_reset();
    wr_mask(1'b1);
    wr_cfg(1'b1, 1'b0);
    repeat (4) @(negedge clk);
    wr_cfg(1'b1, 1'b0);
    count_pulse(n_rem, sa, bm);
    chk(6 + n_rem == PULSE, "R6 length unchanged", 6 + n_rem, PULSE);
    chk(!sa, "R9 no self reset on re-request", sa, 0);

    // R7 init cancels running pulse
    do_reset();
    wr_mask(1'b1);
    wr_cfg(1'b1, 1'b0);
    repeat (3) @(negedge clk);
    wr_cfg(1'b0, 1'b1);
    chk(pin_oe == 1'b0 && busy == 1'b0, "R7 pulse cancelled", pin_oe, 0);
    chk(cfg_rst == 1'b1 && en == 1'b0, "R7 init strobe and enable clear",
        {cfg_rst, en}, 2);
    repeat (3) begin
      @(negedge clk);
      chk(aux_rst == 1'b0, "R9 blank after cancel", aux_rst, 0);
    end

    // R8 external reset through synchronizer
    do_reset();
    wr_mask(1'b1);
    @(negedge clk); ext_n = 1'b0;
    @(negedge clk);
    chk(aux_rst == 1'b0, "R8 one stage latency", aux_rst, 0);
    @(negedge clk);
    chk(aux_rst == 1'b1 && cfg_rst == 1'b1, "R8 both strobes", {aux_rst, cfg_rst}, 3);
    @(negedge clk);
    chk(en == 1'b0, "R8 enable cleared", en, 0);
    ext_n = 1'b1;
    @(negedge clk);
    chk(aux_rst == 1'b1, "R8 held while sync low", aux_rst, 1);
    @(negedge clk);
    chk(aux_rst == 1'b0 && cfg_rst == 1'b0, "R8 released", {aux_rst, cfg_rst}, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule